// File: doc/BRIEF.md
# Triggered Sampling-Array Slot Controller

This block is the digital sequencer for a ring of analog sampling cells that must capture short, rare events at full clock rate. Every clock it enables exactly one cell for sampling and steps a write position forward. The ring can be cut into 1, 2, 4 or 8 equal slots. Writing circles inside one slot and keeps overwriting its oldest cells until a trigger arrives. The trigger freezes that slot together with the cell written in the trigger cycle. Writing then jumps to the start of the next slot that is not frozen, so triggers that arrive at random intervals can be absorbed while earlier captures are still being processed.

Frozen slots wait in a first-in first-out queue. The block takes them one at a time and runs a single-slope conversion on every cell of the slot at once. A shared counter drives the ramp for 2^N clocks, where N is the programmed resolution. Each cell keeps the counter value seen in the first clock its comparator reports high. After the ramp, the slot's codes are streamed out oldest sample first under a valid/ready handshake. The slot returns to the write rotation when its last word is taken.

The comparators, storage capacitors and ramp generator are outside this block. The comparator decisions enter as one input bit per cell. The ramp counter is brought out so that the ramp generator can follow it.

Top module: `tsa_slot_ctrl`

## Requirements
- R1: While writing, `samp_en` has exactly one bit set, at index `wr_cell`. Each clock the position within the active slot advances by one and wraps from the slot's last cell to its first, overwriting old samples. After reset, writing starts at cell 0.
- R2: `cfg_slots` = k selects 2^k slots of 256>>k cells each. Slot s covers cells s*(256>>k) up to s*(256>>k)+(256>>k)-1. Values above 3 are treated as 3.
- R3: A new slot count or resolution takes effect only on a clock with no frozen slot and `trig` low. When it takes effect, writing restarts at cell 0. A change made while any slot is frozen has no effect until then.
- R4: A trigger while writing freezes the active slot, including the cell written in that clock. On the next clock, writing is at offset 0 of the first non-frozen slot found by counting upward from the active slot, with wrap-around. If no such slot exists, writing stops: `samp_en` is 0 and `busy` is 1.
- R5: A trigger while `busy` is 1 is dropped and `lost_cnt` increments by one, saturating at 2^8-1. At all other times `lost_cnt` holds its value.
- R6: When writing has stopped, it resumes at offset 0 of the slot that is released, in the clock after the release.
- R7: Frozen slots are converted and read out in the order in which they were triggered.
- R8: A conversion raises `ramp_run` for exactly 2^N clocks, with `ramp_cnt` counting 0 to 2^N-1. N is `cfg_res` limited to the range 7 to 12.
- R9: A cell's code is the `ramp_cnt` value in the first ramp clock in which its `cmp` bit is 1. A cell whose bit never rises gets the full-scale code 2^N-1.
- R10: A converted slot is read out as 256>>k words. Each word carries the slot index in `out_slot`, the absolute cell in `out_cell` and the code in `out_code`. The words start at the cell after the one written in the trigger clock and run in circular time order. A word is held unchanged while `out_ready` is low.
- R11: A slot rejoins the write rotation only after its last word has been accepted. While readout is stalled, a stopped write stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slots | input | 2 | log2 of the slot count |
| cfg_res | input | 4 | Requested conversion resolution in bits |
| trig | input | 1 | Event trigger, sampled each clock |
| cmp | input | 256 | Per-cell comparator decision |
| samp_en | output | 256 | One-hot sample enable |
| wr_cell | output | 8 | Cell being written this clock |
| busy | output | 1 | All slots frozen; writing stopped |
| lost_cnt | output | 8 | Saturating count of dropped triggers |
| ramp_run | output | 1 | Conversion ramp in progress |
| ramp_cnt | output | 12 | Shared ramp counter value |
| out_valid | output | 1 | Readout word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_slot | output | 3 | Slot index of the word |
| out_cell | output | 8 | Absolute cell index of the word |
| out_code | output | 12 | Converted code |

## Verification
Captures are taken with every slot count and several resolutions, including out-of-range resolution requests that must clamp. Trigger delays are chosen both shorter and longer than one slot, so that the stream start position shows whether the in-slot wrap and the oldest-first order are correct. Comparator thresholds follow a per-cell pattern whose span runs past full scale, which separates first-crossing latching from the full-scale default. A directed sequence fills every slot with readout held off. It exposes the conversion order, the stop and resume of writing, dropped triggers, counter saturation and a configuration change deferred until idle.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

   typedef enum logic [1:0] {
      CV_IDLE = 2'd0,
      CV_RAMP = 2'd1,
      CV_READ = 2'd2
   } cv_state_t;

   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

endpackage

// File: rtl/tsa_write_ctrl.sv
module tsa_write_ctrl
   import tsa_pkg::*;
#(
   parameter int N_CELLS        = 256,
   parameter int MAX_SLOTS_LOG2 = 3,
   parameter int RES_MIN        = 7,
   parameter int RES_MAX        = 12,
   parameter int LOST_W         = 8,
   parameter bit LOST_SATURATE  = 1'b1,
   localparam int CELL_W    = $clog2(N_CELLS),
   localparam int SLOT_W    = MAX_SLOTS_LOG2,
   localparam int MAX_SLOTS = 1 << MAX_SLOTS_LOG2,
   localparam int SL_W      = $clog2(MAX_SLOTS_LOG2 + 1),
   localparam int RES_W     = $clog2(RES_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SL_W-1:0]    cfg_slots_i,
   input  logic [RES_W-1:0]   cfg_res_i,
   input  logic               trig_i,
   input  logic               release_i,
   input  logic [SLOT_W-1:0]  release_slot_i,
   output logic [SL_W-1:0]    act_k_o,
   output logic [RES_W-1:0]   act_res_o,
   output logic [N_CELLS-1:0] samp_en_o,
   output logic [CELL_W-1:0]  wr_cell_o,
   output logic               push_o,
   output logic [SLOT_W-1:0]  push_slot_o,
   output logic [CELL_W-1:0]  push_start_o,
   output logic               busy_o,
   output logic [LOST_W-1:0]  lost_o
);

   logic [SL_W-1:0]      k_req, act_k_q;
   logic [RES_W-1:0]     res_req, act_res_q;
   logic [SLOT_W-1:0]    wr_slot_q, cand_slot, probe, smask;
   logic [CELL_W-1:0]    off_q, len_mask, wr_cell;
   logic [MAX_SLOTS-1:0] frozen_q, set_vec, rel_vec;
   logic [LOST_W-1:0]    lost_q;
   logic                 writing_q, found, idle, cfg_load, accept, drop;

   // sanitised configuration request
   assign k_req   = (cfg_slots_i > SL_W'(MAX_SLOTS_LOG2)) ? SL_W'(MAX_SLOTS_LOG2) : cfg_slots_i;
   assign res_req = RES_W'(clamp_int(int'(cfg_res_i), RES_MIN, RES_MAX));

   assign smask    = SLOT_W'((1 << act_k_q) - 1);
   assign len_mask = {CELL_W{1'b1}} >> act_k_q;
   assign wr_cell  = (CELL_W'(wr_slot_q) << (CELL_W - int'(act_k_q))) | off_q;

   // first free slot after the active one, circular within the active slot count
   always_comb begin
      found     = 1'b0;
      cand_slot = '0;
      probe     = '0;
      for (int i = 1; i < MAX_SLOTS; i++) begin
         probe = SLOT_W'(int'(wr_slot_q) + i) & smask;
         if (!found && (i < (1 << act_k_q)) && !frozen_q[probe]) begin
            found     = 1'b1;
            cand_slot = probe;
         end
      end
   end

   assign idle     = ~|frozen_q;
   assign accept   = trig_i && writing_q;
   assign drop     = trig_i && !writing_q;
   assign cfg_load = idle && !trig_i && ((k_req != act_k_q) || (res_req != act_res_q));
   assign set_vec  = accept    ? (MAX_SLOTS'(1) << wr_slot_q)      : '0;
   assign rel_vec  = release_i ? (MAX_SLOTS'(1) << release_slot_i) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_k_q   <= '0;
         act_res_q <= RES_W'(RES_MAX);
         wr_slot_q <= '0;
         off_q     <= '0;
         writing_q <= 1'b1;
         frozen_q  <= '0;
      end else begin
         frozen_q <= (frozen_q & ~rel_vec) | set_vec;
         if (cfg_load) begin
            act_k_q   <= k_req;
            act_res_q <= res_req;
            wr_slot_q <= '0;
            off_q     <= '0;
            writing_q <= 1'b1;
         end else if (accept) begin
            if (found) begin
               wr_slot_q <= cand_slot;
               off_q     <= '0;
            end else begin
               writing_q <= 1'b0;
            end
         end else if (writing_q) begin
            off_q <= (off_q + 1'b1) & len_mask;
         end else if (release_i) begin
            wr_slot_q <= release_slot_i;
            off_q     <= '0;
            writing_q <= 1'b1;
         end
      end
   end

   generate
      if (LOST_SATURATE) begin : g_lost_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    lost_q <= '0;
            else if (drop && !(&lost_q))   lost_q <= lost_q + 1'b1;
         end
      end else begin : g_lost_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    lost_q <= '0;
            else if (drop) lost_q <= lost_q + 1'b1;
         end
      end
   endgenerate

   assign act_k_o      = act_k_q;
   assign act_res_o    = act_res_q;
   assign wr_cell_o    = wr_cell;
   assign samp_en_o    = writing_q ? (N_CELLS'(1) << wr_cell) : '0;
   assign push_o       = accept;
   assign push_slot_o  = wr_slot_q;
   assign push_start_o = (off_q + 1'b1) & len_mask;
   assign busy_o       = !writing_q;
   assign lost_o       = lost_q;

endmodule

// File: rtl/tsa_slot_fifo.sv
module tsa_slot_fifo #(
   parameter int DEPTH_LOG2 = 3,
   parameter int WIDTH      = 11,
   localparam int DEPTH     = 1 << DEPTH_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             pop_i,
   output logic             valid_o,
   output logic [WIDTH-1:0] dout_o
);

   logic [WIDTH-1:0]      mem_q [DEPTH];
   logic [DEPTH_LOG2-1:0] rd_q, wr_q;
   logic [DEPTH_LOG2:0]   cnt_q;
   logic                  do_push, do_pop;

   assign do_push = push_i && (cnt_q != DEPTH_LOG2'(0) + (DEPTH_LOG2+1)'(DEPTH));
   assign do_pop  = pop_i && (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wr_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + 1'b1;
         if (do_pop)  rd_q <= rd_q + 1'b1;
         cnt_q <= cnt_q + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
      end
   end

   assign valid_o = (cnt_q != '0);
   assign dout_o  = mem_q[rd_q];

endmodule

// File: rtl/tsa_converter.sv
module tsa_converter
   import tsa_pkg::*;
#(
   parameter int N_CELLS        = 256,
   parameter int MAX_SLOTS_LOG2 = 3,
   parameter int RES_MAX        = 12,
   localparam int CELL_W = $clog2(N_CELLS),
   localparam int SLOT_W = MAX_SLOTS_LOG2,
   localparam int SL_W   = $clog2(MAX_SLOTS_LOG2 + 1),
   localparam int RES_W  = $clog2(RES_MAX + 1),
   localparam int CODE_W = RES_MAX
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SL_W-1:0]    act_k_i,
   input  logic [RES_W-1:0]   act_res_i,
   input  logic               q_valid_i,
   input  logic [SLOT_W-1:0]  q_slot_i,
   input  logic [CELL_W-1:0]  q_start_i,
   output logic               q_pop_o,
   input  logic [N_CELLS-1:0] cmp_i,
   output logic               ramp_run_o,
   output logic [CODE_W-1:0]  ramp_cnt_o,
   output logic               out_valid_o,
   input  logic               out_ready_i,
   output logic [SLOT_W-1:0]  out_slot_o,
   output logic [CELL_W-1:0]  out_cell_o,
   output logic [CODE_W-1:0]  out_code_o,
   output logic               release_o,
   output logic [SLOT_W-1:0]  release_slot_o
);

   cv_state_t          st_q;
   logic [SLOT_W-1:0]  slot_q;
   logic [CELL_W-1:0]  start_q, rd_q, len_mask, out_cell;
   logic [CODE_W-1:0]  cnt_q, full;
   logic [CODE_W-1:0]  code_arr [N_CELLS];
   logic               start_conv, ramp_last, last_word;
   int                 sh;

   assign sh         = CELL_W - int'(act_k_i);
   assign len_mask   = {CELL_W{1'b1}} >> act_k_i;
   assign full       = {CODE_W{1'b1}} >> (CODE_W - int'(act_res_i));
   assign start_conv = (st_q == CV_IDLE) && q_valid_i;
   assign ramp_last  = (st_q == CV_RAMP) && (cnt_q == full);
   assign last_word  = (st_q == CV_READ) && out_ready_i && (rd_q == len_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= CV_IDLE;
         slot_q  <= '0;
         start_q <= '0;
         cnt_q   <= '0;
         rd_q    <= '0;
      end else begin
         unique case (st_q)
            CV_IDLE: if (q_valid_i) begin
               slot_q  <= q_slot_i;
               start_q <= q_start_i;
               cnt_q   <= '0;
               st_q    <= CV_RAMP;
            end
            CV_RAMP: begin
               cnt_q <= cnt_q + 1'b1;
               if (ramp_last) begin
                  rd_q <= '0;
                  st_q <= CV_READ;
               end
            end
            CV_READ: if (out_ready_i) begin
               rd_q <= rd_q + 1'b1;
               if (last_word) st_q <= CV_IDLE;
            end
            default: st_q <= CV_IDLE;
         endcase
      end
   end

   // one latch per cell; only cells of the slot under conversion respond
   for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
      logic              hit, done_q;
      logic [CODE_W-1:0] code_q;

      assign hit = ((CELL_W'(c) >> sh) == CELL_W'(slot_q));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done_q <= 1'b0;
            code_q <= '0;
         end else if (start_conv) begin
            done_q <= 1'b0;
         end else if ((st_q == CV_RAMP) && hit && !done_q && (cmp_i[c] || (cnt_q == full))) begin
            code_q <= cnt_q;
            done_q <= 1'b1;
         end
      end

      assign code_arr[c] = code_q;
   end

   assign out_cell = (CELL_W'(slot_q) << sh) | ((start_q + rd_q) & len_mask);

   assign q_pop_o        = start_conv;
   assign ramp_run_o     = (st_q == CV_RAMP);
   assign ramp_cnt_o     = cnt_q;
   assign out_valid_o    = (st_q == CV_READ);
   assign out_slot_o     = slot_q;
   assign out_cell_o     = out_cell;
   assign out_code_o     = code_arr[out_cell];
   assign release_o      = last_word;
   assign release_slot_o = slot_q;

endmodule

// File: rtl/tsa_slot_ctrl.sv
module tsa_slot_ctrl #(
   parameter int N_CELLS        = 256,
   parameter int MAX_SLOTS_LOG2 = 3,
   parameter int RES_MIN        = 7,
   parameter int RES_MAX        = 12,
   parameter int LOST_W         = 8,
   parameter bit LOST_SATURATE  = 1'b1,
   localparam int CELL_W = $clog2(N_CELLS),
   localparam int SLOT_W = MAX_SLOTS_LOG2,
   localparam int SL_W   = $clog2(MAX_SLOTS_LOG2 + 1),
   localparam int RES_W  = $clog2(RES_MAX + 1),
   localparam int CODE_W = RES_MAX
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SL_W-1:0]    cfg_slots,
   input  logic [RES_W-1:0]   cfg_res,
   input  logic               trig,
   input  logic [N_CELLS-1:0] cmp,
   output logic [N_CELLS-1:0] samp_en,
   output logic [CELL_W-1:0]  wr_cell,
   output logic               busy,
   output logic [LOST_W-1:0]  lost_cnt,
   output logic               ramp_run,
   output logic [CODE_W-1:0]  ramp_cnt,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [SLOT_W-1:0]  out_slot,
   output logic [CELL_W-1:0]  out_cell,
   output logic [CODE_W-1:0]  out_code
);

   localparam int Q_W = SLOT_W + CELL_W;

   if (N_CELLS != (1 << CELL_W)) begin : g_bad_cells
      $error("N_CELLS must be a power of two");
   end
   if ((MAX_SLOTS_LOG2 < 1) || (MAX_SLOTS_LOG2 > CELL_W)) begin : g_bad_slots
      $error("MAX_SLOTS_LOG2 out of range");
   end
   if ((RES_MIN < 1) || (RES_MIN > RES_MAX)) begin : g_bad_res
      $error("resolution range is empty");
   end

   logic [SL_W-1:0]   act_k;
   logic [RES_W-1:0]  act_res;
   logic              push, q_valid, q_pop, rel;
   logic [SLOT_W-1:0] push_slot, rel_slot;
   logic [CELL_W-1:0] push_start;
   logic [Q_W-1:0]    q_head;

   tsa_write_ctrl #(
      .N_CELLS(N_CELLS), .MAX_SLOTS_LOG2(MAX_SLOTS_LOG2), .RES_MIN(RES_MIN),
      .RES_MAX(RES_MAX), .LOST_W(LOST_W), .LOST_SATURATE(LOST_SATURATE)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .cfg_slots_i(cfg_slots), .cfg_res_i(cfg_res),
      .trig_i(trig), .release_i(rel), .release_slot_i(rel_slot),
      .act_k_o(act_k), .act_res_o(act_res), .samp_en_o(samp_en), .wr_cell_o(wr_cell),
      .push_o(push), .push_slot_o(push_slot), .push_start_o(push_start),
      .busy_o(busy), .lost_o(lost_cnt)
   );

   tsa_slot_fifo #(.DEPTH_LOG2(MAX_SLOTS_LOG2), .WIDTH(Q_W)) u_q (
      .clk(clk), .rst_n(rst_n), .push_i(push), .din_i({push_slot, push_start}),
      .pop_i(q_pop), .valid_o(q_valid), .dout_o(q_head)
   );

   tsa_converter #(
      .N_CELLS(N_CELLS), .MAX_SLOTS_LOG2(MAX_SLOTS_LOG2), .RES_MAX(RES_MAX)
   ) u_cv (
      .clk(clk), .rst_n(rst_n), .act_k_i(act_k), .act_res_i(act_res),
      .q_valid_i(q_valid), .q_slot_i(q_head[Q_W-1:CELL_W]), .q_start_i(q_head[CELL_W-1:0]),
      .q_pop_o(q_pop), .cmp_i(cmp), .ramp_run_o(ramp_run), .ramp_cnt_o(ramp_cnt),
      .out_valid_o(out_valid), .out_ready_i(out_ready), .out_slot_o(out_slot),
      .out_cell_o(out_cell), .out_code_o(out_code), .release_o(rel), .release_slot_o(rel_slot)
   );

endmodule

// File: rtl/tsa_slot_ctrl_chk.sv
module tsa_slot_ctrl_chk #(
   parameter int N_CELLS        = 256,
   parameter int MAX_SLOTS_LOG2 = 3,
   parameter int RES_MAX        = 12,
   parameter int LOST_W         = 8,
   localparam int CELL_W = $clog2(N_CELLS),
   localparam int SLOT_W = MAX_SLOTS_LOG2,
   localparam int RES_W  = $clog2(RES_MAX + 1),
   localparam int CODE_W = RES_MAX
) (
   input logic               clk,
   input logic               rst_n,
   input logic               trig,
   input logic [N_CELLS-1:0] samp_en,
   input logic [CELL_W-1:0]  wr_cell,
   input logic               busy,
   input logic [LOST_W-1:0]  lost_cnt,
   input logic               ramp_run,
   input logic [CODE_W-1:0]  ramp_cnt,
   input logic               out_valid,
   input logic               out_ready,
   input logic [SLOT_W-1:0]  out_slot,
   input logic [CELL_W-1:0]  out_cell,
   input logic [CODE_W-1:0]  out_code,
   input logic [RES_W-1:0]   act_res
);

   logic [CODE_W-1:0] full;
   assign full = {CODE_W{1'b1}} >> (CODE_W - int'(act_res));

   // R1
   onehot_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(samp_en));

   // R1
   wr_match_chk: assert property (@(posedge clk) disable iff (!rst_n) (|samp_en) |-> samp_en[wr_cell]);

   // R4
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (samp_en == '0));

   // R5
   lost_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && busy && !(&lost_cnt)) |=> (lost_cnt == $past(lost_cnt) + 1'b1));

   // R5
   lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig && busy) |=> $stable(lost_cnt));

   // R8
   ramp_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ramp_run) |-> (ramp_cnt == '0));

   // R8
   ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_run && $past(ramp_run)) |-> (ramp_cnt == $past(ramp_cnt) + 1'b1));

   // R9
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_code <= full));

   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_cell) && $stable(out_code) && $stable(out_slot)));

   // R7
   one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ramp_run && out_valid));

endmodule

bind tsa_slot_ctrl tsa_slot_ctrl_chk #(
   .N_CELLS(N_CELLS), .MAX_SLOTS_LOG2(MAX_SLOTS_LOG2), .RES_MAX(RES_MAX), .LOST_W(LOST_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .trig(trig), .samp_en(samp_en), .wr_cell(wr_cell),
   .busy(busy), .lost_cnt(lost_cnt), .ramp_run(ramp_run), .ramp_cnt(ramp_cnt),
   .out_valid(out_valid), .out_ready(out_ready), .out_slot(out_slot),
   .out_cell(out_cell), .out_code(out_code), .act_res(act_res)
);

// File: tb/tb_tsa_slot_ctrl.sv
`timescale 1ns/1ps
module tb_tsa_slot_ctrl;

   localparam int NC = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_slots = 2'd0;
   logic [3:0]    cfg_res = 4'd12;
   logic          trig = 1'b0;
   logic [NC-1:0] cmp;
   logic [NC-1:0] samp_en;
   logic [7:0]    wr_cell;
   logic          busy;
   logic [7:0]    lost_cnt;
   logic          ramp_run;
   logic [11:0]   ramp_cnt;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [2:0]    out_slot;
   logic [7:0]    out_cell;
   logic [11:0]   out_code;

   always #4 clk = ~clk;

   tsa_slot_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_slots(cfg_slots), .cfg_res(cfg_res), .trig(trig),
      .cmp(cmp), .samp_en(samp_en), .wr_cell(wr_cell), .busy(busy), .lost_cnt(lost_cnt),
      .ramp_run(ramp_run), .ramp_cnt(ramp_cnt), .out_valid(out_valid), .out_ready(out_ready),
      .out_slot(out_slot), .out_cell(out_cell), .out_code(out_code)
   );

   int seed_v = 1;
   int tmod_v = 100;
   int checks = 0;
   int fails  = 0;

   function automatic int tgt(input int c, input int s, input int m);
      return (c * 7 + s) % m;
   endfunction

   // comparator model: a cell fires once the ramp reaches its threshold
   always_comb begin
      for (int c = 0; c < NC; c++) cmp[c] = ramp_run && (int'(ramp_cnt) >= tgt(c, seed_v, tmod_v));
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse_trig();
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic wait_valid();
      for (int t = 0; t < 5000 && !out_valid; t++) @(negedge clk);
   endtask

   // {slot log2, resolution request, threshold span, seed, trigger delay}
   localparam int NV = 6;
   localparam int VEC [NV][5] = '{
      '{0, 7,  200,  3,   5},
      '{1, 8,  300,  11,  40},
      '{2, 10, 1500, 5,   70},
      '{3, 12, 5000, 17,  9},
      '{2, 3,  100,  2,   100},
      '{3, 15, 9000, 1,   33}
   };

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      int k, n, len, nres, full, wc, slot, off, prev, cur, bad, cnt, bad_o, bad_c, got, ecell, ecode, lb;
      int order [4];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state (R1)
      chk(wr_cell == 0 && samp_en == NC'(1), "R1 reset write position", wr_cell, 0);
      chk(!busy && !out_valid && !ramp_run && lost_cnt == 0, "R5 reset status", lost_cnt, 0);

      for (int v = 0; v < NV; v++) begin
         k    = VEC[v][0];
         n    = 1 << k;
         len  = NC >> k;
         nres = (VEC[v][1] < 7) ? 7 : ((VEC[v][1] > 12) ? 12 : VEC[v][1]);
         full = (1 << nres) - 1;
         seed_v = VEC[v][3];
         tmod_v = VEC[v][2];
         out_ready = 1'b1;
         cfg_slots = 2'(k);
         cfg_res   = 4'(VEC[v][1]);
         @(negedge clk);
         chk(wr_cell == 0, "R3 config applied when idle", wr_cell, 0);
         prev = wr_cell;
         bad  = 0;
         repeat (VEC[v][2 + 2]) begin
            @(negedge clk);
            cur = wr_cell;
            if (!((cur / len == prev / len) && (cur % len == (prev % len + 1) % len))) bad++;
            prev = cur;
         end
         chk(bad == 0, "R1 advance and wrap within slot", bad, 0);
         wc   = wr_cell;
         slot = wc / len;
         off  = wc % len;
         pulse_trig();
         if (n > 1) chk(wr_cell == ((slot + 1) % n) * len && !busy, "R4 move to next slot", wr_cell, ((slot + 1) % n) * len);
         else       chk(busy && samp_en == '0, "R4 stop with no free slot", busy, 1);
         for (int t = 0; t < 50 && !ramp_run; t++) @(negedge clk);
         cnt = 0;
         while (ramp_run && cnt < 5000) begin
            cnt++;
            @(negedge clk);
         end
         chk(cnt == (1 << nres), "R8 ramp length", cnt, 1 << nres);
         bad_o = 0; bad_c = 0; got = 0;
         for (int i = 0; i < len; i++) begin
            wait_valid();
            if (out_valid) got++;
            ecell = slot * len + (off + 1 + i) % len;
            ecode = (tgt(ecell, seed_v, tmod_v) > full) ? full : tgt(ecell, seed_v, tmod_v);
            if (out_cell != ecell || out_slot != slot) bad_o++;
            if (out_code != ecode) bad_c++;
            @(negedge clk);
         end
         chk(got == len, "R2 words per slot", got, len);
         chk(bad_o == 0, "R10 time order and slot index", bad_o, 0);
         chk(bad_c == 0, "R9 codes", bad_c, 0);
         if (n == 1) chk(wr_cell == 0 && !busy, "R6 resume after release", wr_cell, 0);
      end

      // directed: four slots filled with readout held off
      seed_v = 5; tmod_v = 150;
      cfg_slots = 2'd2; cfg_res = 4'd7;
      @(negedge clk);
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      pulse_trig();
      chk(wr_cell == 64, "R4 first trigger", wr_cell, 64);
      cfg_slots = 2'd0;
      @(negedge clk);
      @(negedge clk);
      chk(wr_cell / 64 == 1, "R3 change deferred while frozen", wr_cell, 66);
      repeat (4) @(negedge clk);
      pulse_trig();
      chk(wr_cell == 128, "R4 second trigger", wr_cell, 128);
      repeat (4) @(negedge clk);
      pulse_trig();
      chk(wr_cell == 192, "R4 third trigger", wr_cell, 192);
      repeat (4) @(negedge clk);
      pulse_trig();
      chk(busy && samp_en == '0, "R4 all slots frozen", busy, 1);
      lb = lost_cnt;
      pulse_trig();
      chk(lost_cnt == lb + 1, "R5 dropped trigger counted", lost_cnt, lb + 1);
      repeat (200) @(negedge clk);
      chk(busy && out_valid && out_slot == 0, "R11 held while readout stalled", busy, 1);
      out_ready = 1'b1;
      for (int i = 0; i < 256; i++) begin
         wait_valid();
         if (i % 64 == 0) order[i / 64] = out_slot;
         @(negedge clk);
         if (i == 63) chk(wr_cell == 0 && !busy, "R11 slot back after last word", wr_cell, 0);
      end
      for (int g = 0; g < 4; g++) chk(order[g] == g, "R7 conversion order", order[g], g);
      @(negedge clk);
      chk(wr_cell == 0, "R3 deferred change applied at idle", wr_cell, 0);

      // directed: saturation of the lost counter
      out_ready = 1'b0;
      @(negedge clk);
      pulse_trig();
      trig = 1'b1;
      repeat (300) @(negedge clk);
      trig = 1'b0;
      @(negedge clk);
      chk(lost_cnt == 255, "R5 saturation", lost_cnt, 255);
      out_ready = 1'b1;
      for (int i = 0; i < 256; i++) begin
         wait_valid();
         @(negedge clk);
      end
      chk(!busy && wr_cell == 0, "R6 resume after drain", wr_cell, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule